// File: doc/BRIEF.md
# GPIO-Triggered Reset Sequencer

This block turns a general-purpose input pin into a one-shot reset source. Software arms it with a single write pulse. While armed and idle, the block watches the pin, now synchronized into the processor-clock domain. The pin is sampled on each pulse of a reference-clock tick, which stands for one cycle of a 3.6864 MHz reference clock. When the pin has been seen high on four consecutive ticks, the block waits out a fixed latency and pulls its active-low reset output low. It then holds that output low for 512 times a programmable multiplier N of processor clock cycles, and releases it on the next reference tick.

Firing clears the arm bit and sets a sticky status bit. The pin is then ignored until software arms the block again. Before arming, software can read the synchronized pin level, so it can avoid arming while the pin is already active. If a frequency change was in progress at the moment the reset fired, release also waits for the PLL lock indication.

The state machine has five states:
- IDLE: waiting. While armed, the pin filter runs.
- DELAY: counting out the fixed latency after the filter qualifies.
- HOLD: counting 512×N processor cycles with the output low.
- LOCK: waiting for PLL lock.
- TAIL: waiting for the next reference tick before release.

The transitions are:
- IDLE→DELAY: the filter qualifies.
- DELAY→HOLD: the third reference tick after qualification. The output falls, the arm bit clears and the status bit sets.
- HOLD→LOCK: the hold count ends and a frequency change was latched.
- HOLD→TAIL: the hold count ends and no frequency change was latched.
- LOCK→TAIL: the synchronized lock indication is seen.
- TAIL→IDLE: a reference tick arrives. The output releases.

Top module: `gpio_reset_seq`

## Requirements
- R1: A pin assertion is accepted only when the synchronized pin is high on 4 consecutive reference ticks. A pulse visible to at most 3 ticks never lowers `rst_out_n` and leaves `armed` at 1.
- R2: With the block armed, `rst_out_n` falls between 6 and 8 reference ticks after the pin rises and stays high.
- R3: With no frequency change latched, `rst_out_n` stays low for at least 512×N processor cycles and at most 512×N cycles plus 4 reference-tick periods. N is `mult_n` sampled when the output falls.
- R4: `mult_n` = 0 gives the same low time as N = 1.
- R5: A one-cycle `arm_set` pulse while the block is idle sets `armed` to 1. `armed` returns to 0 on the same clock edge on which `rst_out_n` falls.
- R6: `fired` becomes 1 on the edge on which `rst_out_n` falls. A `status_clr` pulse returns it to 0.
- R7: While `armed` is 0, the pin has no effect: `rst_out_n` stays high.
- R8: If `freq_chg` is high when the output falls, release also waits until `pll_lock` has been high, then follows within 4 reference-tick periods plus 3 cycles.
- R9: `arm_set` is ignored while `rst_out_n` is low: `armed` is still 0 after release.
- R10: `pin_level` equals `pin_in` delayed by two processor clock edges.
- R11: After reset, `rst_out_n` is 1, and `armed` and `fired` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| ref_tick | input | 1 | One-cycle pulse per reference-clock period |
| pin_in | input | 1 | Asynchronous GPIO reset pin, active high |
| arm_set | input | 1 | Software pulse that arms the pin as a reset source |
| status_clr | input | 1 | Software pulse that clears `fired` |
| mult_n | input | N_W | Hold multiplier N; 0 is treated as 1 |
| freq_chg | input | 1 | Frequency change in progress (asynchronous) |
| pll_lock | input | 1 | PLL lock indication (asynchronous) |
| pin_level | output | 1 | Synchronized pin level for software |
| armed | output | 1 | Arm bit |
| fired | output | 1 | Sticky flag: a pin reset occurred |
| rst_out_n | output | 1 | Active-low reset output |

## Verification
Several pin patterns are applied.
- A short pulse that only three ticks can see, against a long one held until the output falls, shows whether the four-tick filter separates noise from a real request.
- A long pulse with the block disarmed, both at the start and after each firing, shows one-shot behaviour as opposed to a level-sensitive source.
- Random multipliers including 0 and 15 distinguish the N scaling and the zero-as-one rule.
- Frequency-change events, with lock arriving before the hold ends, after it ends, or already present, separate the lock wait from the plain hold count.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_DELAY = 3'd1,
        ST_HOLD  = 3'd2,
        ST_LOCK  = 3'd3,
        ST_TAIL  = 3'd4
    } seq_state_t;
endpackage

// File: rtl/sync2.sv
module sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/tick_filter.sv
module tick_filter #(
    parameter int MIN_TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic tick,
    input  logic level,
    output logic qualified
);
    localparam int CW = $clog2(MIN_TICKS + 1);

    logic [CW-1:0] run_cnt;

    // run_cnt counts consecutive ticks with level high; any low level clears it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (!enable || !level) begin
            run_cnt <= '0;
        end else if (tick && run_cnt != CW'(MIN_TICKS)) begin
            run_cnt <= run_cnt + CW'(1);
        end
    end

    assign qualified = enable && level && tick && (run_cnt == CW'(MIN_TICKS - 1));
endmodule

// File: rtl/span_timer.sv
module span_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    output logic [W-1:0] remaining
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remaining <= '0;
        end else if (load) begin
            remaining <= load_val;
        end else if (step && remaining != '0) begin
            remaining <= remaining - W'(1);
        end
    end
endmodule

// File: rtl/gpio_reset_seq.sv
module gpio_reset_seq
    import rstseq_pkg::*;
#(
    parameter int MIN_TICKS   = 4,
    parameter int DELAY_TICKS = 3,
    parameter int HOLD_UNIT   = 512,
    parameter int N_W         = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ref_tick,
    input  logic           pin_in,
    input  logic           arm_set,
    input  logic           status_clr,
    input  logic [N_W-1:0] mult_n,
    input  logic           freq_chg,
    input  logic           pll_lock,
    output logic           pin_level,
    output logic           armed,
    output logic           fired,
    output logic           rst_out_n
);
    localparam int DLY_W  = $clog2(DELAY_TICKS + 1);
    localparam int HOLD_W = $clog2(HOLD_UNIT) + N_W + 1;

    logic [2:0]        sync_q;
    logic              pin_s, lock_s, fchg_s;
    seq_state_t        state_q, state_d;
    logic              qualified;
    logic              go_delay, go_hold, hold_last;
    logic [DLY_W-1:0]  dly_left;
    logic [HOLD_W-1:0] hold_left, hold_target;
    logic [N_W-1:0]    n_eff;
    logic              need_lock_q;

    sync2 #(.W(3)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({freq_chg, pll_lock, pin_in}),
        .q     (sync_q)
    );
    assign pin_s  = sync_q[0];
    assign lock_s = sync_q[1];
    assign fchg_s = sync_q[2];
    assign pin_level = pin_s;

    tick_filter #(.MIN_TICKS(MIN_TICKS)) u_filt (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (armed && state_q == ST_IDLE),
        .tick      (ref_tick),
        .level     (pin_s),
        .qualified (qualified)
    );

    assign n_eff       = (mult_n == '0) ? N_W'(1) : mult_n;
    assign hold_target = HOLD_W'(HOLD_UNIT) * HOLD_W'(n_eff);

    assign go_delay  = (state_q == ST_IDLE) && qualified;
    assign go_hold   = (state_q == ST_DELAY) && ref_tick && (dly_left == DLY_W'(1));
    assign hold_last = (state_q == ST_HOLD) && (hold_left == HOLD_W'(1));

    span_timer #(.W(DLY_W)) u_dly (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (go_delay),
        .load_val  (DLY_W'(DELAY_TICKS)),
        .step      (ref_tick && state_q == ST_DELAY),
        .remaining (dly_left)
    );

    span_timer #(.W(HOLD_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (go_hold),
        .load_val  (hold_target),
        .step      (state_q == ST_HOLD),
        .remaining (hold_left)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (go_delay) state_d = ST_DELAY;
            ST_DELAY: if (go_hold) state_d = ST_HOLD;
            ST_HOLD:  if (hold_last) state_d = need_lock_q ? ST_LOCK : ST_TAIL;
            ST_LOCK:  if (lock_s) state_d = ST_TAIL;
            ST_TAIL:  if (ref_tick) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs and latched event context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_out_n   <= 1'b1;
            armed       <= 1'b0;
            fired       <= 1'b0;
            need_lock_q <= 1'b0;
        end else begin
            rst_out_n <= !(state_d == ST_HOLD || state_d == ST_LOCK || state_d == ST_TAIL);
            if (go_hold) begin
                armed       <= 1'b0;
                fired       <= 1'b1;
                need_lock_q <= fchg_s;
            end else begin
                if (arm_set && state_q == ST_IDLE) armed <= 1'b1;
                if (status_clr) fired <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/rstseq_checker.sv
module rstseq_checker #(
    parameter int HOLD_UNIT = 512,
    parameter int N_W       = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           pin_in,
    input logic [N_W-1:0] mult_n,
    input logic           pin_level,
    input logic           armed,
    input logic           fired,
    input logic           rst_out_n
);
    logic [1:0]     age;
    logic [17:0]    low_cnt;
    logic [N_W-1:0] n_cap;
    logic [17:0]    need_low;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age     <= '0;
            low_cnt <= '0;
            n_cap   <= '0;
        end else begin
            if (age != 2'd2) age <= age + 2'd1;
            if (rst_out_n) begin
                low_cnt <= '0;
                n_cap   <= mult_n;
            end else if (low_cnt != '1) begin
                low_cnt <= low_cnt + 18'd1;
            end
        end
    end

    assign need_low = 18'(HOLD_UNIT) * 18'((n_cap == '0) ? 1 : int'(n_cap));

    a_r3_min_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_out_n) |-> (low_cnt + 18'd1 >= need_low));

    a_r5_arm_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_out_n) |-> !armed);

    a_r6_fired_sets: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_out_n) |-> fired);

    a_r7_unarmed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_out_n && !armed) |=> rst_out_n);

    a_r9_no_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_out_n |=> !armed);

    a_r10_level: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd2) |-> (pin_level == $past(pin_in, 2)));
endmodule

bind gpio_reset_seq rstseq_checker #(.HOLD_UNIT(HOLD_UNIT), .N_W(N_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_in    (pin_in),
    .mult_n    (mult_n),
    .pin_level (pin_level),
    .armed     (armed),
    .fired     (fired),
    .rst_out_n (rst_out_n)
);

// File: tb/sim_gpio_reset_seq.sv
`timescale 1ns/1ps
module sim_gpio_reset_seq;
    localparam int REF_DIV = 27;
    localparam int UNIT    = 512;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_tick = 1'b0;
    logic       pin_in = 1'b0;
    logic       arm_set = 1'b0;
    logic       status_clr = 1'b0;
    logic [3:0] mult_n = 4'd1;
    logic       freq_chg = 1'b0;
    logic       pll_lock = 1'b1;
    logic       pin_level, armed, fired, rst_out_n;

    int checks = 0;
    int failures = 0;
    int tick_cnt = 0;
    int div_cnt = 0;

    always #5 clk = ~clk;

    gpio_reset_seq u0 (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .pin_in(pin_in),
        .arm_set(arm_set), .status_clr(status_clr), .mult_n(mult_n),
        .freq_chg(freq_chg), .pll_lock(pll_lock), .pin_level(pin_level),
        .armed(armed), .fired(fired), .rst_out_n(rst_out_n)
    );

    always @(negedge clk) begin
        if (div_cnt == REF_DIV - 1) begin
            div_cnt  <= 0;
            ref_tick <= 1'b1;
        end else begin
            div_cnt  <= div_cnt + 1;
            ref_tick <= 1'b0;
        end
    end

    always @(posedge clk) if (ref_tick) tick_cnt <= tick_cnt + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int hold_cycles(input int n);
        return UNIT * ((n == 0) ? 1 : n);
    endfunction

    task automatic do_arm();
        @(negedge clk) arm_set = 1'b1;
        @(negedge clk) arm_set = 1'b0;
    endtask

    // pulse the pin for w cycles, report whether rst_out_n fell in a settle window
    task automatic quiet_pulse(input int w, output bit saw_low);
        saw_low = 1'b0;
        @(negedge clk) pin_in = 1'b1;
        repeat (w) begin
            @(negedge clk);
            if (!rst_out_n) saw_low = 1'b1;
        end
        pin_in = 1'b0;
        repeat (12 * REF_DIV) begin
            @(negedge clk);
            if (!rst_out_n) saw_low = 1'b1;
        end
    endtask

    task automatic run_event(input int n, input bit fc, input int lockd, input string tag);
        int t0, lc, lo, hi, guard;
        mult_n   = 4'(n);
        freq_chg = fc;
        pll_lock = !(fc && lockd > 0);
        do_arm();
        check(armed == 1'b1, "R5 armed after arm_set", int'(armed), 1);
        @(negedge clk) pin_in = 1'b1;
        t0 = tick_cnt;
        guard = 0;
        while (rst_out_n && guard < 20 * REF_DIV) begin
            @(negedge clk);
            guard++;
        end
        check(tick_cnt - t0 >= 6 && tick_cnt - t0 <= 8, "R2 latency ticks", tick_cnt - t0, 7);
        check(armed == 1'b0, "R5 armed cleared at fire", int'(armed), 0);
        check(fired == 1'b1, "R6 fired set", int'(fired), 1);
        lc = 0;
        while (!rst_out_n && lc < 40000) begin
            @(negedge clk);
            lc++;
            if (lc == 3) pin_in = 1'b0;
            if (lc == 100) arm_set = 1'b1;
            if (lc == 101) arm_set = 1'b0;
            if (fc && lc == lockd) pll_lock = 1'b1;
        end
        lo = hold_cycles(n);
        if (fc && lockd > lo) lo = lockd;
        hi = lo + 4 * REF_DIV + 6;
        check(lc >= lo && lc <= hi, tag, lc, lo);
        check(armed == 1'b0, "R9 arm ignored while low", int'(armed), 0);
        freq_chg = 1'b0;
        pll_lock = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        bit saw;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        check(rst_out_n == 1'b1, "R11 reset rst_out_n", int'(rst_out_n), 1);
        check(armed == 1'b0, "R11 reset armed", int'(armed), 0);
        check(fired == 1'b0, "R11 reset fired", int'(fired), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R10: level visible two edges later
        @(negedge clk) pin_in = 1'b1;
        @(negedge clk);
        check(pin_level == 1'b0, "R10 level after one edge", int'(pin_level), 0);
        @(negedge clk);
        check(pin_level == 1'b1, "R10 level after two edges", int'(pin_level), 1);
        pin_in = 1'b0;
        repeat (4) @(negedge clk);

        // R7: disarmed long pulse
        quiet_pulse(10 * REF_DIV, saw);
        check(!saw, "R7 unarmed pulse ignored", int'(saw), 0);

        // R1: short pulse seen by at most 3 ticks
        do_arm();
        quiet_pulse(2 * REF_DIV, saw);
        check(!saw, "R1 short pulse ignored", int'(saw), 0);
        check(armed == 1'b1, "R1 still armed", int'(armed), 1);

        run_event(2, 1'b0, 0, "R3 hold N=2");
        quiet_pulse(10 * REF_DIV, saw);
        check(!saw, "R7 one-shot after fire", int'(saw), 0);

        @(negedge clk) status_clr = 1'b1;
        @(negedge clk) status_clr = 1'b0;
        check(fired == 1'b0, "R6 status_clr", int'(fired), 0);

        run_event(0, 1'b0, 0, "R4 N=0 as 1");
        run_event(15, 1'b0, 0, "R3 hold N=15");
        run_event(1, 1'b1, 3000, "R8 late lock");
        run_event(4, 1'b1, 200, "R8 early lock");
        run_event(3, 1'b1, 0, "R8 lock present");

        for (int k = 0; k < 5; k++) begin
            int n, ld;
            bit fc;
            n  = int'($urandom % 8);
            fc = 1'($urandom % 2);
            ld = 100 + int'($urandom % 5000);
            run_event(n, fc, ld, fc ? "R8 random" : "R3 random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule